// File: doc/BRIEF.md
# Sequenced Trigger Capture Unit

This block is an embedded capture engine for on-chip debug. It watches two single-bit trigger lines, each tested by its own equality match unit against a compare bit, and runs a small sequencer over the match results. The sequencer is either one level (match unit 0 alone fires the trigger) or two levels (match unit 0 must be seen first, then match unit 1 on a later cycle). Once the trigger fires, the block stores every clock's value of a 47-bit sample bus into a 256-entry internal memory, then raises a completion flag.

Compare bits and the sequencer depth are held in small registers written through a one-bit write port with a select code. They can be changed at run time between captures. An arm pulse restarts the sequencer. After a capture, the stored words are read back through an address/data read port. In the intended use, the sample word packs a 12-bit operand in bits 11:0, an 8-bit operand in bits 19:12 and a 27-bit accumulated result in bits 46:20. The block treats the word as opaque.

Top module: `seq_trig_capture`

## Requirements
- R1: After reset, `waiting`, `capturing`, `done` and `rdValid` are 0. The compare bit of match unit 0 is 0, the compare bit of match unit 1 is 1, and two-level mode is selected.
- R2: A write with `cfgWrEn`=1 loads `cfgWrData` into the register picked by `cfgSel`: 0 sets the unit 0 compare bit, 1 sets the unit 1 compare bit, and 2 sets the mode (1 selects two levels, 0 selects one level). The new value governs matching from the next clock on.
- R3: An `arm` pulse, from any state including mid-capture, puts the sequencer at level 0. On the next clock `waiting`=1, `capturing`=0 and `done`=0.
- R4: While not armed (after reset, or after `done`), trigger inputs have no effect: `capturing` stays 0.
- R5: At level 0, only match unit 0 (`trigIn[0]` equal to its compare bit) advances the sequencer. A match on unit 1 alone at level 0 is not remembered.
- R6: If both match units are true on the clock that satisfies level 0 in two-level mode, the sequencer goes only to level 1. `capturing` rises no earlier than one clock later.
- R7: In one-level mode, a unit 0 match at level 0 starts capture on that clock.
- R8: Capture lasts exactly 256 clocks. The `sampleIn` value present during the k-th cycle with `capturing`=1 is stored at address k, for k = 0 to 255.
- R9: After the 256th stored sample, `capturing` falls and `done`=1. No further writes happen until the next arm.
- R10: With `rdEn`=1 while `capturing`=0, `rdData` shows the word at `rdAddr` one clock later, with `rdValid`=1. With `rdEn`=1 during capture, `rdValid` is 0 and `rdData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart sequencer at level 0 and clear done |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 unit0 bit, 1 unit1 bit, 2 mode |
| cfgWrData | input | 1 | Value written to the selected register |
| trigIn | input | 2 | Trigger lines, bit i feeds match unit i |
| sampleIn | input | 47 | Sample bus recorded during capture |
| rdEn | input | 1 | Read request |
| rdAddr | input | 8 | Read address |
| rdData | output | 47 | Read word, valid one clock after request |
| rdValid | output | 1 | rdData was updated by the previous request |
| waiting | output | 1 | Armed, sequencer at level 0 or 1 |
| capturing | output | 1 | Samples being written |
| done | output | 1 | Buffer full since last arm |

## Verification
The bench drives both match units true on the same clock. A sequencer that skipped level 1 would start capture one clock early. It also holds unit 1 true before unit 0, and a design that latched that early match would trigger out of order. The bench reprograms the compare bits and the mode so that the reset values no longer match. Stale configuration would then trigger on the wrong polarity, or fail to fire in one-level mode. Off-by-one write pointers show up as misplaced words at addresses 0 and 255. Reads attempted during capture, and trigger activity after `done`, expose a read port that is not blocked and a capture that restarts on its own.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

  // Sequencer state: idle, level 0, level 1, storing, full
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LVL0 = 3'd1,
    ST_LVL1 = 3'd2,
    ST_CAPT = 3'd3,
    ST_DONE = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store sampleIn at the write address this clock
    logic rdAllow;  // read port may serve requests
  } capStrobe_t;

  localparam logic [1:0] SEL_MODE = 2'd2;

endpackage

// File: rtl/seq_trig_ctrl.sv
module seq_trig_ctrl
  import seq_trig_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          arm,
  input  logic          cfgWrEn,
  input  logic [1:0]    cfgSel,
  input  logic          cfgWrData,
  input  logic [1:0]    trigIn,
  output capStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic          waiting,
  output logic          capturing,
  output logic          done
);

  localparam int          NUM_MATCH = 2;
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [NUM_MATCH-1:0] matchVal;
  logic [NUM_MATCH-1:0] hit;
  logic                 twoLevelQ;
  seqState_t            stateQ, stateD;
  logic [AW-1:0]        ptrQ, ptrD;

  // One equality match unit per trigger line, compare bit set at run time
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    localparam logic RST_VAL = 1'(i % 2);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) matchVal[i] <= RST_VAL;
      else if (cfgWrEn && cfgSel == 2'(i)) matchVal[i] <= cfgWrData;
    end
    assign hit[i] = (trigIn[i] == matchVal[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) twoLevelQ <= 1'b1;
    else if (cfgWrEn && cfgSel == SEL_MODE) twoLevelQ <= cfgWrData;
  end

  always_comb begin
    stateD = stateQ;
    ptrD   = ptrQ;
    if (arm) begin
      stateD = ST_LVL0;
      ptrD   = '0;
    end else begin
      unique case (stateQ)
        ST_LVL0: if (hit[0]) stateD = twoLevelQ ? ST_LVL1 : ST_CAPT;
        ST_LVL1: if (hit[1]) stateD = ST_CAPT;
        ST_CAPT: begin
          ptrD = ptrQ + AW'(1);
          if (ptrQ == LAST) stateD = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      ptrQ   <= '0;
    end else begin
      stateQ <= stateD;
      ptrQ   <= ptrD;
    end
  end

  assign strobe.wrEn    = (stateQ == ST_CAPT);
  assign strobe.rdAllow = (stateQ != ST_CAPT);
  assign wrAddr         = ptrQ;
  assign waiting        = (stateQ == ST_LVL0) || (stateQ == ST_LVL1);
  assign capturing      = (stateQ == ST_CAPT);
  assign done           = (stateQ == ST_DONE);

  // R3: arm always lands on level 0 with done cleared
  a_r3_arm_restarts: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (waiting && !capturing && !done));

  // R4: idle or full, nothing but arm moves the sequencer
  a_r4_unarmed_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_IDLE || stateQ == ST_DONE) && !arm) |=> $stable(stateQ));

  // R6: in two-level mode, level 0 never jumps straight into capture
  a_r6_no_level_skip: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LVL0 && twoLevelQ && !arm) |=> (stateQ != ST_CAPT));

  // R8: write address steps by one per stored sample
  a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CAPT && ptrQ != LAST && !arm) |=>
      (stateQ == ST_CAPT && ptrQ == $past(ptrQ) + AW'(1)));

  // R9: last address written ends the capture
  a_r9_full_stops: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CAPT && ptrQ == LAST && !arm) |=> (done && !capturing));

endmodule

// File: rtl/seq_trig_dpath.sv
module seq_trig_dpath
  import seq_trig_pkg::*;
#(
  parameter int DATA_W = 47,
  parameter int DEPTH  = 256,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [DATA_W-1:0] sampleMem [DEPTH];
  logic              rdGo;

  assign rdGo = rdEn && strobe.rdAllow;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) sampleMem[wrAddr] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdGo;
      if (rdGo) rdData <= sampleMem[rdAddr];
    end
  end

  // R10: a request made while storing is refused
  a_r10_no_read_in_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && rdEn) |=> !rdValid);

  // R10: without a served request the read word holds
  a_r10_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdGo |=> $stable(rdData));

endmodule

// File: rtl/seq_trig_capture.sv
module seq_trig_capture
  import seq_trig_pkg::*;
#(
  parameter int DATA_W = 47,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic              cfgWrData,
  input  logic [1:0]        trigIn,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              rdEn,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              waiting,
  output logic              capturing,
  output logic              done
);

  capStrobe_t    strobe;
  logic [AW-1:0] wrAddr;

  seq_trig_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .arm       (arm),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .trigIn    (trigIn),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .waiting   (waiting),
    .capturing (capturing),
    .done      (done)
  );

  seq_trig_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .sampleIn (sampleIn),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: tb/seq_trig_capture_tb.sv
module seq_trig_capture_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        arm, cfgWrEn, cfgWrData, rdEn;
  logic [1:0]  cfgSel, trigIn;
  logic [46:0] sampleIn, rdData;
  logic [7:0]  rdAddr;
  logic        rdValid, waiting, capturing, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  seq_trig_capture u_dut (
    .clk(clk), .rstN(rstN), .arm(arm), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .trigIn(trigIn), .sampleIn(sampleIn), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .waiting(waiting),
    .capturing(capturing), .done(done)
  );

  function automatic logic [46:0] pat(int i, int s);
    return {27'(i * i + s * 1000), 8'(i ^ s), 12'(i * 7 + s)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic val);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = val;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic doArm();
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  task automatic stream(int seed);
    for (int i = 0; i < 256; i++) begin
      sampleIn = pat(i, seed);
      chk("R8 capturing during capture", capturing, 1);
      step();
    end
    chk("R9 done after last sample", done, 1);
    chk("R9 capturing falls", capturing, 0);
  endtask

  task automatic readAt(string tag, logic [7:0] a, logic [46:0] exp);
    rdEn = 1'b1; rdAddr = a;
    step();
    rdEn = 1'b0;
    chk({tag, " rdValid"}, rdValid, 1);
    chk({tag, " rdData"}, rdData, exp);
  endtask

  task automatic t_reset();
    chk("R1 waiting", waiting, 0);
    chk("R1 capturing", capturing, 0);
    chk("R1 done", done, 0);
    chk("R1 rdValid", rdValid, 0);
  endtask

  task automatic t_idle_ignore();
    trigIn = 2'b10;  // both units match under reset compare bits
    repeat (4) step();
    chk("R4 idle capturing", capturing, 0);
    chk("R4 idle waiting", waiting, 0);
  endtask

  task automatic t_ordered();
    doArm();
    chk("R3 arm waiting", waiting, 1);
    trigIn = 2'b11;  // unit 1 matches, unit 0 not
    repeat (3) step();
    chk("R5 unit1 alone ignored", capturing, 0);
    chk("R5 still waiting", waiting, 1);
    trigIn = 2'b00;  // unit 0 only
    step();
    chk("R5 level1 not capturing", capturing, 0);
    chk("R5 level1 waiting", waiting, 1);
    trigIn = 2'b10;
    step();
    chk("R5 second match starts capture", capturing, 1);
    chk("R5 waiting drops", waiting, 0);
    stream(5);
    readAt("R8 addr0", 8'd0, pat(0, 5));
    readAt("R8 addr1", 8'd1, pat(1, 5));
    readAt("R8 addr100", 8'd100, pat(100, 5));
    readAt("R10 addr255", 8'd255, pat(255, 5));
    trigIn = 2'b00; sampleIn = '1;
    step();
    trigIn = 2'b10;
    repeat (3) step();
    chk("R4 done ignores triggers", capturing, 0);
    chk("R9 done holds", done, 1);
    readAt("R9 no write after done", 8'd0, pat(0, 5));
  endtask

  task automatic t_same_cycle();
    doArm();
    chk("R3 arm clears done", done, 0);
    trigIn = 2'b10;  // both match at level 0
    step();
    chk("R6 only level1 reached", capturing, 0);
    step();
    chk("R6 capture one clock later", capturing, 1);
    rdEn = 1'b1; rdAddr = 8'd0;
    step();
    rdEn = 1'b0;
    chk("R10 no read in capture", rdValid, 0);
    chk("R10 rdData held", rdData, pat(0, 5));
    trigIn = 2'b01;
    doArm();
    chk("R3 arm aborts capture", capturing, 0);
    chk("R3 arm mid-capture waits", waiting, 1);
  endtask

  task automatic t_reprogram();
    cfgWrite(2'd0, 1'b1);
    cfgWrite(2'd1, 1'b0);
    trigIn = 2'b10;  // matches old values, neither new one
    doArm();
    repeat (3) step();
    chk("R2 old compare bits dead", capturing, 0);
    chk("R2 still waiting", waiting, 1);
    trigIn = 2'b01;  // both new matches at once
    step();
    chk("R6 reprogrammed same cycle", capturing, 0);
    step();
    chk("R2 new compare bits fire", capturing, 1);
    doArm();
  endtask

  task automatic t_single_level();
    cfgWrite(2'd2, 1'b0);
    trigIn = 2'b00;
    doArm();
    step();
    chk("R7 no match no capture", capturing, 0);
    trigIn = 2'b01;
    step();
    chk("R7 one level fires", capturing, 1);
    stream(9);
    readAt("R7 addr0", 8'd0, pat(0, 9));
    readAt("R8 addr7", 8'd7, pat(7, 9));
    readAt("R8 addr255", 8'd255, pat(255, 9));
    doArm();
    chk("R3 rearm clears done", done, 0);
    chk("R3 rearm waiting", waiting, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; arm = 1'b0; cfgWrEn = 1'b0; cfgSel = '0; cfgWrData = 1'b0;
    trigIn = 2'b01; sampleIn = '0; rdEn = 1'b0; rdAddr = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_idle_ignore();
    t_ordered();
    t_same_cycle();
    t_reprogram();
    t_single_level();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule